// File: doc/BRIEF.md
# Congestion Notification Request Generator

This block sits in the receive path of a network adapter. For every received packet it is told the packet's flow number and the two-bit ECN field. When that field shows the congestion-experienced code, the block may ask the transmit side to send a congestion notification back to the sender of that flow. Each request is a small descriptor: the flow number, which later logic turns into the sender's address, and a fixed packet length of 64 bytes.

Notifications are rate limited per flow. A table holds one last-notification timestamp and one valid bit for each flow. A congestion mark produces a request only when the flow has no valid entry, or when at least the programmed gap has passed since its entry was stamped. Other marks are absorbed without any output. The gap is given in microseconds, resets to 50 and can be reloaded. Ages are computed by modular subtraction on a free-running microsecond counter, so counter wraparound does no harm.

The output is a single valid/ready request register controlled by a two-state machine:
- S_IDLE: no request is held. An accepted mark moves it to S_SEND.
- S_SEND: a request is held. With ready low it stays in S_SEND and holds the request (hold). With ready high and a new accepted mark it stays in S_SEND and loads the new request (reload). With ready high and no new mark it returns to S_IDLE (drain).

While a request is held and not being taken, no mark is accepted and the table is left unchanged. This means duplicates for the same flow never queue up.

Top module: `cnp_gen`

## Requirements
- R1: Only the ECN code 2'b11 (congestion experienced) can produce a request. The codes 2'b00, 2'b01 and 2'b10 never do, and they leave the table unchanged.
- R2: After reset, req_valid is 0, every table entry is invalid and the gap is 50 µs.
- R3: A request carries the marked packet's flow number on req_flow and the value 64 on req_len.
- R4: A CE-marked packet on a flow with no valid entry is accepted. req_valid is 1 from the clock edge that samples rx_valid.
- R5: A CE-marked packet is accepted only if its age, (now_us − stamp) mod 2^TS_W, is at least the gap. Accepting writes now_us into the entry. A mark with a smaller age is absorbed with no table update.
- R6: While req_valid is 1 and req_ready is 0, req_valid, req_flow and req_len stay unchanged. A request is consumed at a clock edge where req_valid and req_ready are both 1.
- R7: While a request is held with req_ready at 0, incoming marks are not accepted and do not update the table. Repeated marks for the held flow therefore create no extra requests.
- R8: A pulse on gap_wr loads gap_din as the new gap, which applies to marks from the next cycle on. A gap of 0 accepts every CE mark while the output is free.
- R9: Age is computed modulo 2^TS_W, so a stamp taken just before the counter wraps is aged correctly after the wrap.
- R10: Table entries are independent: a recent stamp on one flow does not block a mark on another flow.
- R11: A mark arriving in the same cycle as a handshake is accepted, and the new request appears at that edge with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received-packet strobe |
| rx_flow | input | FLOW_W (8) | Flow number of the received packet |
| rx_ecn | input | 2 | ECN field of the received packet |
| now_us | input | TS_W (16) | Free-running microsecond timebase |
| gap_wr | input | 1 | Load strobe for the gap register |
| gap_din | input | TS_W (16) | New gap in microseconds |
| req_valid | output | 1 | Notification request pending |
| req_ready | input | 1 | Downstream accepts the request |
| req_flow | output | FLOW_W (8) | Flow to notify |
| req_len | output | LEN_W (8) | Notification length in bytes (64) |

## Verification
The assertions check on every cycle that:
- a held request stays stable under back-pressure;
- a new request only follows a CE-marked packet;
- the idle state never drives a request;
- every table write leaves the entry valid and holding the written time.

The spacing rule itself needs specific timestamp sequences, so the bench shows it with scenarios:
- the exact 49/50 µs boundary;
- a timebase wrap;
- independent flows;
- a reprogrammed gap, including zero.

The bench also shows:
- that marks arriving during back-pressure leave no trace in the table;
- back-to-back acceptance during a handshake;
- that reset clears the valid bits.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
    localparam logic [1:0] ECN_CE       = 2'b11;
    localparam int         NOTIFY_BYTES = 64;
    localparam int         GAP_RESET_US = 50;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } req_state_t;
endpackage

// File: rtl/cnp_ecn_check.sv
module cnp_ecn_check (
    input  logic       rx_valid,
    input  logic [1:0] rx_ecn,
    output logic       marked
);
    import cnp_pkg::*;

    always_comb begin
        marked = rx_valid && (rx_ecn == ECN_CE);
    end
endmodule

// File: rtl/cnp_flow_table.sv
module cnp_flow_table #(
    parameter int FLOWS  = 256,
    parameter int TS_W   = 16,
    parameter int FLOW_W = $clog2(FLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLOW_W-1:0] look_flow,
    input  logic [TS_W-1:0]   now_us,
    input  logic [TS_W-1:0]   gap_us,
    output logic              due,
    input  logic              wr_en,
    input  logic [FLOW_W-1:0] wr_flow,
    input  logic [TS_W-1:0]   wr_time
);
    logic              vld_q   [FLOWS];
    logic [TS_W-1:0]   stamp_q [FLOWS];
    logic [TS_W-1:0]   age;

    // Valid bits are cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FLOWS; i++) begin
                vld_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            vld_q[wr_flow] <= 1'b1;
        end
    end

    // Stamps are only meaningful when their valid bit is set, so they take no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            stamp_q[wr_flow] <= wr_time;
        end
    end

    // Modular age: the subtraction wraps in TS_W bits.
    always_comb begin
        age = now_us - stamp_q[look_flow];
        due = !vld_q[look_flow] || (age >= gap_us);
    end

    // R5: a written entry becomes valid and holds the written time.
    p_stamp_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_flow)] && stamp_q[$past(wr_flow)] == $past(wr_time)));
endmodule

// File: rtl/cnp_req_fsm.sv
module cnp_req_fsm #(
    parameter int FLOW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mark_ok,
    input  logic [FLOW_W-1:0] mark_flow,
    input  logic              req_ready,
    output logic              accept,
    output logic              req_valid,
    output logic [FLOW_W-1:0] req_flow
);
    import cnp_pkg::*;

    req_state_t state_q, state_d;
    logic       slot_free;

    always_comb begin
        slot_free = (state_q == S_IDLE) || req_ready;
        accept    = mark_ok && slot_free;
        state_d   = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_SEND;
            S_SEND: begin
                if (req_ready && !accept) state_d = S_IDLE;
                else                      state_d = S_SEND;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_flow  <= '0;
        end else if (accept) begin
            req_valid <= 1'b1;
            req_flow  <= mark_flow;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

    // R6: a stalled request holds.
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_flow)));

    // R2: the idle state never presents a request.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !req_valid);
endmodule

// File: rtl/cnp_gen.sv
module cnp_gen #(
    parameter int FLOWS  = 256,
    parameter int TS_W   = 16,
    parameter int LEN_W  = 8,
    localparam int FLOW_W = $clog2(FLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [FLOW_W-1:0] rx_flow,
    input  logic [1:0]        rx_ecn,
    input  logic [TS_W-1:0]   now_us,
    input  logic              gap_wr,
    input  logic [TS_W-1:0]   gap_din,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [FLOW_W-1:0] req_flow,
    output logic [LEN_W-1:0]  req_len
);
    import cnp_pkg::*;

    logic            marked;
    logic            due;
    logic            mark_ok;
    logic            accept;
    logic [TS_W-1:0] gap_q;

    // Programmable notification gap in microseconds.
    always_ff @(posedge clk) begin
        if (!rst_n)      gap_q <= TS_W'(GAP_RESET_US);
        else if (gap_wr) gap_q <= gap_din;
    end

    cnp_ecn_check u_ecn (
        .rx_valid (rx_valid),
        .rx_ecn   (rx_ecn),
        .marked   (marked)
    );

    cnp_flow_table #(
        .FLOWS  (FLOWS),
        .TS_W   (TS_W),
        .FLOW_W (FLOW_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_flow (rx_flow),
        .now_us    (now_us),
        .gap_us    (gap_q),
        .due       (due),
        .wr_en     (accept),
        .wr_flow   (rx_flow),
        .wr_time   (now_us)
    );

    always_comb begin
        mark_ok = marked && due;
        req_len = LEN_W'(NOTIFY_BYTES);
    end

    cnp_req_fsm #(
        .FLOW_W (FLOW_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_ok   (mark_ok),
        .mark_flow (rx_flow),
        .req_ready (req_ready),
        .accept    (accept),
        .req_valid (req_valid),
        .req_flow  (req_flow)
    );

    // R1: a new request only follows a CE-marked packet.
    p_mark_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(rx_valid && rx_ecn == ECN_CE));
endmodule

// File: tb/test_cnp_gen.sv
module test_cnp_gen;
    localparam int FLOWS  = 256;
    localparam int TS_W   = 16;
    localparam int LEN_W  = 8;
    localparam int FLOW_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [FLOW_W-1:0] rx_flow = '0;
    logic [1:0]        rx_ecn = '0;
    logic [TS_W-1:0]   now_us = '0;
    logic              gap_wr = 1'b0;
    logic [TS_W-1:0]   gap_din = '0;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [FLOW_W-1:0] req_flow;
    logic [LEN_W-1:0]  req_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cnp_gen #(.FLOWS(FLOWS), .TS_W(TS_W), .LEN_W(LEN_W)) i_cnp_gen (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flow(rx_flow),
        .rx_ecn(rx_ecn), .now_us(now_us), .gap_wr(gap_wr), .gap_din(gap_din),
        .req_valid(req_valid), .req_ready(req_ready), .req_flow(req_flow),
        .req_len(req_len)
    );

    typedef struct packed {
        logic [7:0]  flow;
        logic [1:0]  ecn;
        logic [15:0] t;
        logic        exp;
        logic [7:0]  eflow;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd5,   2'b11, 16'd100,   1'b1, 8'd5},    // R4 first mark
        '{8'd5,   2'b11, 16'd120,   1'b0, 8'd0},    // R5 age 20
        '{8'd5,   2'b11, 16'd149,   1'b0, 8'd0},    // R5 age 49
        '{8'd5,   2'b11, 16'd150,   1'b1, 8'd5},    // R5 age 50
        '{8'd7,   2'b10, 16'd150,   1'b0, 8'd0},    // R1
        '{8'd7,   2'b01, 16'd150,   1'b0, 8'd0},    // R1
        '{8'd7,   2'b00, 16'd150,   1'b0, 8'd0},    // R1
        '{8'd7,   2'b11, 16'd151,   1'b1, 8'd7},    // R10
        '{8'd5,   2'b11, 16'd160,   1'b0, 8'd0},    // R5 age 10
        '{8'd255, 2'b11, 16'd65530, 1'b1, 8'd255},  // R9 stamp before wrap
        '{8'd255, 2'b11, 16'd43,    1'b0, 8'd0},    // R9 age 49 across wrap
        '{8'd255, 2'b11, 16'd44,    1'b1, 8'd255},  // R9 age 50 across wrap
        '{8'd0,   2'b11, 16'd44,    1'b1, 8'd0}     // R10 flow 0
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; leaves at a negedge with the request drained.
    task automatic do_mark(input logic [7:0] f, input logic [1:0] e,
                           input logic [15:0] t, input bit exp,
                           input logic [7:0] ef, input string tag);
        rx_valid = 1'b1; rx_flow = f; rx_ecn = e; now_us = t;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(req_valid == exp, {tag, " req_valid"}, int'(req_valid), int'(exp));
        if (exp) begin
            chk(req_flow == ef, {tag, " req_flow"}, int'(req_flow), int'(ef));
            chk(req_len == 8'd64, "R3 req_len", int'(req_len), 64);
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "R2 reset req_valid", int'(req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R2 idle after reset", int'(req_valid), 0);

        for (int i = 0; i < NV; i++) begin
            do_mark(VECS[i].flow, VECS[i].ecn, VECS[i].t, VECS[i].exp,
                    VECS[i].eflow, "R1/R3/R4/R5/R9/R10 vector");
        end

        // R6 / R7: back-pressure holds; marks during the stall leave no trace.
        req_ready = 1'b0;
        rx_valid = 1'b1; rx_flow = 8'd20; rx_ecn = 2'b11; now_us = 16'd1000;
        @(negedge clk);
        chk(req_valid && req_flow == 8'd20, "R6 loaded", int'(req_flow), 20);
        now_us = 16'd1100;
        @(negedge clk);
        chk(req_valid && req_flow == 8'd20, "R7 same-flow during stall", int'(req_flow), 20);
        rx_flow = 8'd21;
        @(negedge clk);
        chk(req_valid && req_flow == 8'd20, "R6 hold", int'(req_flow), 20);
        rx_valid = 1'b0;
        req_ready = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R6 consumed", int'(req_valid), 0);
        do_mark(8'd21, 2'b11, 16'd1101, 1'b1, 8'd21, "R7 other flow untouched");
        do_mark(8'd20, 2'b11, 16'd1020, 1'b0, 8'd0, "R7 stamp not refreshed");

        // R11: back-to-back acceptance during the handshake.
        rx_valid = 1'b1; rx_flow = 8'd30; rx_ecn = 2'b11; now_us = 16'd2000;
        @(negedge clk);
        chk(req_valid && req_flow == 8'd30, "R11 first", int'(req_flow), 30);
        rx_flow = 8'd31;
        @(negedge clk);
        chk(req_valid && req_flow == 8'd31, "R11 second", int'(req_flow), 31);
        rx_valid = 1'b0;
        @(negedge clk);
        chk(req_valid == 1'b0, "R11 drained", int'(req_valid), 0);

        // R8: programmable gap.
        gap_wr = 1'b1; gap_din = 16'd10;
        @(negedge clk);
        gap_wr = 1'b0;
        do_mark(8'd40, 2'b11, 16'd3000, 1'b1, 8'd40, "R8 gap10 first");
        do_mark(8'd40, 2'b11, 16'd3009, 1'b0, 8'd0,  "R8 gap10 age9");
        do_mark(8'd40, 2'b11, 16'd3010, 1'b1, 8'd40, "R8 gap10 age10");
        gap_wr = 1'b1; gap_din = 16'd0;
        @(negedge clk);
        gap_wr = 1'b0;
        do_mark(8'd40, 2'b11, 16'd3010, 1'b1, 8'd40, "R8 gap0 age0");

        // R2: reset clears entries and restores the 50 us gap.
        do_mark(8'd50, 2'b11, 16'd6000, 1'b1, 8'd50, "R2 pre-reset stamp");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R2 req_valid after reset", int'(req_valid), 0);
        do_mark(8'd50, 2'b11, 16'd6010, 1'b1, 8'd50, "R2 entry cleared");
        do_mark(8'd50, 2'b11, 16'd6059, 1'b0, 8'd0,  "R2 gap 50 age49");
        do_mark(8'd50, 2'b11, 16'd6060, 1'b1, 8'd50, "R2 gap 50 age50");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule